// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and a byte-wide asynchronous static RAM that is selected by a pair of enables of opposite polarity, and that has active-low output-enable and write-enable strobes. The host raises a request with an address, a direction flag and write data while the block signals ready. The block then plays out the pin sequence for one read or one write. It ends each access with a one-cycle done pulse, and after a read it presents the captured byte.

Every timing window is given in nanoseconds as a parameter and turned into a whole number of clock cycles by rounding up against the clock period. The windows are cycle time, address access, the bus release after output or chip disable, the bus release after the write strobe falls, the strobe width and the data setup. A read holds the memory selected for the longer of cycle time and access time, samples the bus in the last of those cycles, and then waits out the release window with the memory deselected. A write lowers the strobe with the data bus undriven, drives data only once the release window has passed, and raises the strobe and drops the data together. A standby input parks the memory deselected. When standby is released, one full cycle time of recovery passes before a new request is accepted.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, with no request pending, the pins are idle: `sram_ce_n_o`=1, `sram_ce_o`=0, `sram_oe_n_o`=1, `sram_we_n_o`=1, `sram_dq_oe_o`=0. `ready_o`=1 and `done_o`=0.
- R2: A read accepted at a clock edge holds the memory selected with `sram_oe_n_o`=0 and `sram_we_n_o`=1 for N_RD = max(N_RC, N_AA) cycles from the next cycle (9 at defaults), where N_x = ceil(x_ns*1000/CLK_PS).
- R3: `rdata_o` takes the value on `sram_dq_i` in the last of the N_RD read cycles. It keeps that value until the next read completes, and writes do not change it.
- R4: After the read window the memory is deselected with `sram_oe_n_o`=1 and the bus undriven for N_HZ cycles (4), and only then does `ready_o` return.
- R5: A write first holds the memory selected with `sram_oe_n_o`=1, `sram_we_n_o`=0 and `sram_dq_oe_o`=0 for N_WHZ cycles (4). The data bus is never driven in the cycle in which the strobe falls.
- R6: The bus is then driven with the write data, strobe still low, for N_WD = max(N_DS, N_WP - N_WHZ) cycles (4). The strobe stays low for at least N_WP cycles (7), and the data are driven at least N_DS cycles (4) before it rises.
- R7: After the strobe rises (with the data released at the same edge), the memory stays deselected for N_WEND = max(1, N_RC - N_WHZ - N_WD) cycles (1), so a write spans at least N_RC cycles.
- R8: `done_o` is a one-cycle pulse in the first cycle in which `ready_o` is high again after each access.
- R9: Requests are accepted only at an edge where `ready_o` is high. A request held, or changed, while busy starts no access.
- R10: `standby_i` high while idle drops `ready_o` at once and keeps the memory deselected. After the first edge that samples `standby_i` low, `ready_o` stays low for N_RDR = N_RC further cycles (9).
- R11: Requests raised during standby or recovery are ignored.
- R12: `sram_addr_o` equals the accepted address and is stable while the memory is selected. `sram_dq_o` equals the accepted write data whenever the bus is driven.
- R13: The bus is never driven while the output strobe is low. The write strobe is never low while the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Host address |
| wdata_i | input | 8 | Host write data |
| standby_i | input | 1 | Request low-power deselect |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle access completion pulse |
| rdata_o | output | 8 | Last read byte |
| sram_addr_o | output | 18 | Memory address pins |
| sram_ce_n_o | output | 1 | Active-low chip enable |
| sram_ce_o | output | 1 | Active-high chip enable |
| sram_oe_n_o | output | 1 | Active-low output enable |
| sram_we_n_o | output | 1 | Active-low write enable |
| sram_dq_o | output | 8 | Data bus drive value |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 8 | Data bus sampled value |

## Verification
The hardest case is a write that starts on the first cycle `ready_o` returns after a read, because that is where a late bus release from the memory could collide with write data. The bench issues its accesses back to back, so many reads are followed at once by a write. Its memory model keeps driving the bus for the release window after deselect and reports any overlap. The model returns a garbage byte until the access time has elapsed, so a capture that comes too early shows up as wrong read data. Standby is entered with a request already held high, and the request is dropped before release so that the recovery count is observed on `ready_o`.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_TA, ST_WR_WE, ST_WR_DAT, ST_WR_END, ST_STBY, ST_RECOV
  } seq_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_dpath.sv
`timescale 1ns/1ps
module sram_seq_dpath #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (acc_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (cap_i)  rdata_o <= dq_i;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CLK_PS   = 8000,
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_HZ_NS  = 25,
  parameter int T_WHZ_NS = 30,
  parameter int T_WP_NS  = 55,
  parameter int T_DS_NS  = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          standby_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_n_o,
  output logic          sram_ce_o,
  output logic          sram_oe_n_o,
  output logic          sram_we_n_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int N_RC   = ns2cyc(T_RC_NS, CLK_PS);
  localparam int N_AA   = ns2cyc(T_AA_NS, CLK_PS);
  localparam int N_HZ   = ns2cyc(T_HZ_NS, CLK_PS);
  localparam int N_WHZ  = ns2cyc(T_WHZ_NS, CLK_PS);
  localparam int N_WP   = ns2cyc(T_WP_NS, CLK_PS);
  localparam int N_DS   = ns2cyc(T_DS_NS, CLK_PS);
  localparam int N_RD   = imax(N_RC, N_AA);
  localparam int N_WD   = imax(N_DS, N_WP - N_WHZ);
  localparam int N_WEND = imax(1, N_RC - N_WHZ - N_WD);
  localparam int N_RDR  = N_RC;
  localparam int N_MAX  = imax(imax(imax(N_RD, N_HZ), imax(N_WHZ, N_WD)), imax(N_WEND, N_RDR));
  localparam int CW     = $clog2(N_MAX + 1);

  seq_state_e    st_q, st_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          zero;
  logic          accept;
  logic          done_q;

  assign ready_o = (st_q == ST_IDLE) && !standby_i;
  assign accept  = ready_o && req_i;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (standby_i) st_d = ST_STBY;
        else if (req_i) begin
          ld = 1'b1;
          if (we_i) begin st_d = ST_WR_WE; ld_val = CW'(N_WHZ - 1); end
          else      begin st_d = ST_RD;    ld_val = CW'(N_RD - 1);  end
        end
      end
      ST_RD:     if (zero) begin st_d = ST_RD_TA;  ld = 1'b1; ld_val = CW'(N_HZ - 1);   end
      ST_RD_TA:  if (zero) st_d = ST_IDLE;
      ST_WR_WE:  if (zero) begin st_d = ST_WR_DAT; ld = 1'b1; ld_val = CW'(N_WD - 1);   end
      ST_WR_DAT: if (zero) begin st_d = ST_WR_END; ld = 1'b1; ld_val = CW'(N_WEND - 1); end
      ST_WR_END: if (zero) st_d = ST_IDLE;
      ST_STBY:   if (!standby_i) begin st_d = ST_RECOV; ld = 1'b1; ld_val = CW'(N_RDR - 1); end
      ST_RECOV:  if (zero) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= zero && ((st_q == ST_RD_TA) || (st_q == ST_WR_END));
    end
  end

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(zero)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (accept),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .cap_i  ((st_q == ST_RD) && zero),
    .dq_i   (sram_dq_i),
    .addr_o (sram_addr_o),
    .wdata_o(sram_dq_o),
    .rdata_o(rdata_o)
  );

  // pin decode from the state register only
  logic sel;
  assign sel          = (st_q == ST_RD) || (st_q == ST_WR_WE) || (st_q == ST_WR_DAT);
  assign sram_ce_n_o  = !sel;
  assign sram_ce_o    = sel;
  assign sram_oe_n_o  = (st_q != ST_RD);
  assign sram_we_n_o  = !((st_q == ST_WR_WE) || (st_q == ST_WR_DAT));
  assign sram_dq_oe_o = (st_q == ST_WR_DAT);
  assign done_o       = done_q;

  // strobe-low run length, saturating
  logic [15:0] we_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               we_run_q <= '0;
    else if (sram_we_n_o)      we_run_q <= '0;
    else if (we_run_q != '1)   we_run_q <= we_run_q + 1'b1;
  end

  // R13
  bus_no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_oe_n_o && sram_ce_o && !sram_ce_n_o));
  // R13
  we_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (sram_ce_o && !sram_ce_n_o && sram_oe_n_o));
  // R5
  drive_after_we_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (!sram_we_n_o && $past(!sram_we_n_o)));
  // R6
  we_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_run_q >= 16'(N_WP)));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_ce_o && $past(sram_ce_o)) |-> $stable(sram_addr_o));
  // R9
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_ce_o || !sram_we_n_o) |-> !ready_o);
endmodule

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
  localparam int PER_PS = 8000;
  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_RC   = cyc(70);
  localparam int C_AA   = cyc(70);
  localparam int C_HZ   = cyc(25);
  localparam int C_WHZ  = cyc(30);
  localparam int C_WP   = cyc(55);
  localparam int C_DS   = cyc(30);
  localparam int C_RD   = mx(C_RC, C_AA);
  localparam int C_WD   = mx(C_DS, C_WP - C_WHZ);
  localparam int C_WEND = mx(1, C_RC - C_WHZ - C_WD);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, stby = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, done, ce_n, ce, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_o;
  logic [7:0] dq_i = 8'hEE;
  logic [17:0] s_addr;

  always #4 clk = ~clk;

  sram_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .standby_i(stby), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .sram_addr_o(s_addr), .sram_ce_n_o(ce_n), .sram_ce_o(ce),
    .sram_oe_n_o(oe_n), .sram_we_n_o(we_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        sel, oe_n, we_n, dq_oe, ready, done;
    logic        chk_addr;
    logic [17:0] addr;
    logic        chk_data;
    logic [7:0]  data;
    logic        chk_rd;
    logic [7:0]  rd;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [7:0] sb [int];
  logic [7:0] mem [int];
  logic [7:0] last_rd = 8'h00;

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req_tag, what, act, expv, $time);
    end
  endtask

  // memory model: keeps bus for C_HZ after release, garbage before access time
  bit drv_prev = 0, wr_prev = 0;
  logic [17:0] a_prev;
  logic [7:0] d_prev;
  int rd_age = 0, tail = 0, we_age = 0;
  always @(posedge clk) begin
    if (drv_prev) begin rd_age++; tail = C_HZ; end
    else begin rd_age = 0; if (tail > 0) tail--; end
    if (wr_prev) mem[int'(a_prev)] = d_prev;
    if (rst_n && !we_n) we_age++; else we_age = 0;
    #1;
    drv_prev = !ce_n && ce && !oe_n && we_n;
    wr_prev  = ce && !ce_n && !we_n && dq_oe;
    a_prev   = s_addr;
    d_prev   = dq_o;
    if (drv_prev && rd_age >= C_AA - 1)
      dq_i = mem.exists(int'(s_addr)) ? mem[int'(s_addr)] : 8'h00;
    else
      dq_i = 8'hEE;
  end

  // per-cycle comparison
  int lowcnt = 0, dqcnt = 0;
  always @(negedge clk) begin
    exp_t e;
    logic [6:0] av, ev;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e = '0;
      e.tag = (stby && req) ? 4'd11 : (stby ? 4'd10 : 4'd1);
      e.oe_n = 1; e.we_n = 1; e.ready = !stby;
    end
    av = {ce_n, ce, oe_n, we_n, dq_oe, ready, done};
    ev = {!e.sel, e.sel, e.oe_n, e.we_n, e.dq_oe, e.ready, e.done};
    chk(av == ev, tname(e.tag), "pins{ce_n,ce,oe_n,we_n,dq_oe,ready,done}", av, ev);
    if (e.chk_addr) chk(s_addr == e.addr, "R12", "address", s_addr, e.addr);
    if (e.chk_data) chk(dq_o == e.data, "R12", "write data", dq_o, e.data);
    if (e.chk_rd)   chk(rdata == e.rd, "R3", "read data", rdata, e.rd);
    if (dq_oe) begin
      chk(!(drv_prev || tail > 0), "R13", "bus contention", tail, 0);
      chk(we_age >= C_WHZ, "R5", "drive after strobe fall", we_age, C_WHZ);
    end
    if (!we_n) begin
      lowcnt++;
      if (dq_oe) dqcnt++;
    end else if (lowcnt > 0) begin
      chk(lowcnt >= C_WP, "R6", "strobe width", lowcnt, C_WP);
      chk(dqcnt >= C_DS, "R6", "data setup", dqcnt, C_DS);
      lowcnt = 0; dqcnt = 0;
    end
  end

  task automatic push(input exp_t e, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endtask

  // called at posedge+2 with the block idle
  task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit busy_req);
    exp_t e;
    req = 1; we = wr; addr = a; wdata = d;
    @(negedge clk); #1;
    e = '0; e.chk_addr = 1; e.addr = a; e.sel = 1; e.oe_n = 1; e.we_n = 1;
    if (!wr) begin
      e.tag = busy_req ? 4'd9 : 4'd2; e.oe_n = 0;
      push(e, C_RD);
      e = '0; e.tag = 4'd4; e.oe_n = 1; e.we_n = 1;
      push(e, C_HZ);
      last_rd = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
    end else begin
      e.tag = busy_req ? 4'd9 : 4'd5; e.we_n = 0;
      push(e, C_WHZ);
      e.tag = 4'd6; e.dq_oe = 1; e.chk_data = 1; e.data = d;
      push(e, C_WD);
      e = '0; e.tag = 4'd7; e.oe_n = 1; e.we_n = 1;
      push(e, C_WEND);
      sb[int'(a)] = d;
    end
    e = '0; e.tag = 4'd8; e.oe_n = 1; e.we_n = 1; e.ready = 1; e.done = 1;
    e.chk_rd = 1; e.rd = last_rd;
    push(e, 1);
    @(posedge clk); #2;
    if (busy_req) begin
      we = !wr; addr = a ^ 18'h1; wdata = ~d;
      repeat (3) begin @(posedge clk); #2; end
    end
    req = 0;
    while (exp_q.size() > 0) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_t e;
    // R1: reset state compared every cycle by the default record
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk); #2;

    access(1, 18'h00000, 8'h5A, 0);
    access(1, 18'h3FFFF, 8'hA5, 0);
    access(1, 18'h12345, 8'h3C, 0);
    access(0, 18'h3FFFF, 8'h00, 0);
    access(0, 18'h00000, 8'h00, 0);
    access(0, 18'h12345, 8'h00, 0);
    // write straight after read, then read back (R4, R13)
    access(1, 18'h12345, 8'hC3, 0);
    access(0, 18'h12345, 8'h00, 0);
    // request held and altered while busy (R9)
    access(0, 18'h00000, 8'h00, 1);
    access(1, 18'h2AAAA, 8'h77, 1);
    access(0, 18'h2AAAA, 8'h00, 0);
    // standby with request pending (R10, R11)
    stby = 1;
    repeat (3) begin @(posedge clk); #2; end
    req = 1; we = 0; addr = 18'h00000;
    repeat (5) begin @(posedge clk); #2; end
    req = 0;
    @(posedge clk); #2;
    stby = 0;
    e = '0; e.tag = 4'd10; e.oe_n = 1; e.we_n = 1; e.ready = 0;
    push(e, 1 + C_RC);
    while (exp_q.size() > 0) @(posedge clk);
    #2;
    access(0, 18'h3FFFF, 8'h00, 0);
    // pattern sweep
    for (int i = 0; i < 16; i++)
      access(1, 18'((i * 18'h2A5F3 + 18'h155) & 18'h3FFFF), 8'((i * 29 + 7) & 8'hFF), 0);
    for (int i = 15; i >= 0; i--)
      access(0, 18'((i * 18'h2A5F3 + 18'h155) & 18'h3FFFF), 8'h00, 0);
    for (int i = 0; i < 8; i++) begin
      access(1, 18'(i * 18'h0101), 8'(8'hF0 ^ i), 0);
      access(0, 18'(i * 18'h0101), 8'h00, 0);
    end
    repeat (4) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule